// File: doc/BRIEF.md
# Codec serial frame interface

This block is the digital serial port and the configuration register file of a voice-band codec. It is a slave on a synchronous four-wire serial link. The host drives the bit clock, the frame sync and the serial data in; the block drives the serial data out and a separate output enable that the pad uses to float the line. Each primary frame moves one 16-bit audio word in each direction. The word from the host goes to the digital-to-analog path on a parallel port, with a one-cycle valid pulse. The word going to the host is taken from the parallel converter sample port.

The least significant bit of every host audio word is a request flag. When it is set, the next frame on the link is a secondary control frame. That frame either writes an 8-bit configuration register or returns its contents. The host places it halfway between two primary frames, and no primary frame is skipped to make room for it. The stored fields go out as ports to the gain stages, the clock multiplier and the power and loopback controls. All link inputs are oversampled in the system clock domain.

The frame engine is a four-state machine. `HUNT_PRI` waits for a sampled frame sync and moves to `XFER_PRI`. `XFER_PRI` shifts 16 bits. After the last bit it goes to `HUNT_SEC` if the flag bit was 1, and back to `HUNT_PRI` if it was 0. `HUNT_SEC` waits for a frame sync and moves to `XFER_SEC`. `XFER_SEC` shifts 16 bits and always returns to `HUNT_PRI`.

Top module: `codec_sif`

## Requirements
- R1: A frame begins at the falling SCLK edge that samples FSYNC high. The 16 data bits follow, MSB first. They are driven on the next 16 rising edges and sampled on the 16 falling edges that follow. During a primary frame `sdo_oe` is high for all 16 bits.
- R2: The outgoing primary word is captured from `adc_sample` at the falling edge that starts the frame. Later changes to `adc_sample` do not alter the bits sent in that frame.
- R3: After the 16th bit of a primary frame, `dac_word` shows the received word with bit 0 forced to 0. `dac_valid` is high for exactly one clock for each primary frame.
- R4: Received bit 0 = 1 in a primary frame makes the next frame a secondary frame. Bit 0 = 0 makes the next frame a primary frame, whose contents then change no register.
- R5: The frame after a secondary frame is always a primary frame, whatever bit 0 of the secondary word holds.
- R6: Secondary word layout: bit 13 is read (1) or write (0), bits 12:8 are the register address and bits 7:0 are the write data. A write updates the addressed register, and `sdo_oe` stays low for the whole frame.
- R7: In a secondary read, `sdo_oe` is low during bits 15:8. During bits 7:0 it is high and `sdo` carries the register contents, MSB first. An address with no register reads as 0x00.
- R8: After reset the two volume registers hold 0x5C and all other registers hold 0x00.
- R9: The volume registers are at address 0x06 (receive) and 0x07 (transmit). Bits 6:2 are the gain code (10111 = 0 dB, 11111 = +12 dB, 00000 = -34.5 dB, 1.5 dB per step) and go out on `*_gain`. Bits 1:0 are active-low mutes and go out on `*_mute_n`. Bit 7 reads as 0.
- R10: The mode register is at address 0x01. Bit 3 drives `chip_pd`, bit 2 drives `loop_ana` and bit 1 drives `loop_dig`. Bits 7:4 and bit 0 read as 0.
- R11: The clock divider value is at address 0x03 and the clock multiplier value is at address 0x04. Each is a full 8-bit read/write register holding the wanted value minus one, and each drives its own output port.
- R12: The status register at address 0x0A is read-only. Bit 7 reflects `short_l`, bit 6 reflects `short_r`, and the other bits read 0. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock from the host |
| fsync | input | 1 | Frame sync, high for one bit time before the MSB |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means the line floats |
| adc_sample | input | 16 | Sample to send in the next primary frame |
| dac_word | output | 16 | Last received audio word, bit 0 cleared |
| dac_valid | output | 1 | One-clock pulse when `dac_word` updates |
| short_l | input | 1 | Left speaker short flag |
| short_r | input | 1 | Right speaker short flag |
| chip_pd | output | 1 | Forced power-down |
| loop_ana | output | 1 | Analog-side loopback select |
| loop_dig | output | 1 | Digital-side loopback select |
| pll_div | output | 8 | Divider value minus one |
| pll_mul | output | 8 | Multiplier value minus one |
| rx_gain | output | 5 | Receive gain code |
| rx_mute_n | output | 2 | Receive active-low mutes |
| tx_gain | output | 5 | Transmit gain code |
| tx_mute_n | output | 2 | Transmit active-low mutes |

## Verification
Primary frames are run with all-zeros, all-ones, alternating, single-bit and mixed words in both directions. This separates a reversed bit order, an off-by-one bit slip and a stuck line, and shows whether the flag bit is cleared on the parallel output. Secondary frames write patterns that set bits the register should not keep, such as reserved bits, read-only status and bit 0 of the mode register, and then read them back. A word that looks like a valid write command is sent in an unflagged primary frame and again right after a secondary frame. This shows that the frame type follows the flag and is not inferred from the contents. The transmit sample is changed in the middle of a frame to locate the instant it is captured, and one secondary frame is placed at the half-period spacing the host uses in service.

// File: rtl/codec_sif_pkg.sv
package codec_sif_pkg;

    typedef enum logic [1:0] {
        ST_HUNT_PRI = 2'd0,
        ST_XFER_PRI = 2'd1,
        ST_HUNT_SEC = 2'd2,
        ST_XFER_SEC = 2'd3
    } sif_state_e;

    localparam int REG_DW = 8;
    localparam int REG_AW = 5;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } reg_wr_t;

    localparam logic [REG_AW-1:0] A_MODE   = 5'h01;
    localparam logic [REG_AW-1:0] A_DIV    = 5'h03;
    localparam logic [REG_AW-1:0] A_MUL    = 5'h04;
    localparam logic [REG_AW-1:0] A_RXVOL  = 5'h06;
    localparam logic [REG_AW-1:0] A_TXVOL  = 5'h07;
    localparam logic [REG_AW-1:0] A_STATUS = 5'h0A;

    localparam logic [REG_DW-1:0] VOL_RESET = 8'h5C;

endpackage

// File: rtl/codec_sif_sync.sv
module codec_sif_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/codec_sif_frame.sv
module codec_sif_frame
    import codec_sif_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DATA_W = REG_DW,
    parameter int ADDR_W = REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fsync_s,
    input  logic              sdi_s,
    input  logic [WORD_W-1:0] adc_sample,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    output reg_wr_t           wr,
    output sif_state_e        state,
    output logic              rd_mode
);

    localparam int CNT_W  = $clog2(WORD_W);
    localparam int RW_BIT = DATA_W + ADDR_W;
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(DATA_W);

    sif_state_e        nxt;
    logic              sclk_d;
    logic              rise, fall, last;
    logic [CNT_W-1:0]  bitcnt;
    logic [WORD_W-1:0] rx_sh, rx_next, tx_sh;

    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign last    = (bitcnt == '0);
    assign rx_next = {rx_sh[WORD_W-2:0], sdi_s};
    assign rd_addr = rx_next[ADDR_W-1:0];

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT_PRI: if (fall && fsync_s) nxt = ST_XFER_PRI;
            ST_XFER_PRI: if (fall && last)    nxt = sdi_s ? ST_HUNT_SEC : ST_HUNT_PRI;
            ST_HUNT_SEC: if (fall && fsync_s) nxt = ST_XFER_SEC;
            ST_XFER_SEC: if (fall && last)    nxt = ST_HUNT_PRI;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT_PRI;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rd_mode   <= 1'b0;
            sdo       <= 1'b0;
            sdo_oe    <= 1'b0;
            dac_word  <= '0;
            dac_valid <= 1'b0;
            wr        <= '0;
        end else begin
            sclk_d    <= sclk_s;
            dac_valid <= 1'b0;
            wr.we     <= 1'b0;
            if (fall) begin
                unique case (state)
                    ST_HUNT_PRI, ST_HUNT_SEC: begin
                        if (fsync_s) begin
                            bitcnt  <= CNT_TOP;
                            rd_mode <= 1'b0;
                            tx_sh   <= (state == ST_HUNT_PRI) ? adc_sample : '0;
                        end
                    end
                    ST_XFER_PRI: begin
                        rx_sh  <= rx_next;
                        bitcnt <= bitcnt - 1'b1;
                        if (last) begin
                            dac_word  <= {rx_next[WORD_W-1:1], 1'b0};
                            dac_valid <= 1'b1;
                        end
                    end
                    ST_XFER_SEC: begin
                        rx_sh  <= rx_next;
                        bitcnt <= bitcnt - 1'b1;
                        if (bitcnt == CNT_ADDR && rx_next[ADDR_W]) begin
                            rd_mode <= 1'b1;
                            tx_sh   <= {rd_data, {(WORD_W-DATA_W){1'b0}}};
                        end
                        if (last && !rx_next[RW_BIT]) begin
                            wr.we   <= 1'b1;
                            wr.addr <= rx_next[DATA_W +: ADDR_W];
                            wr.data <= rx_next[DATA_W-1:0];
                        end
                    end
                endcase
            end else if (rise) begin
                unique case (state)
                    ST_XFER_PRI: begin
                        sdo    <= tx_sh[WORD_W-1];
                        tx_sh  <= tx_sh << 1;
                        sdo_oe <= 1'b1;
                    end
                    ST_XFER_SEC: begin
                        sdo    <= tx_sh[WORD_W-1];
                        tx_sh  <= tx_sh << 1;
                        sdo_oe <= rd_mode;
                    end
                    ST_HUNT_PRI, ST_HUNT_SEC: begin
                        sdo    <= 1'b0;
                        sdo_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/codec_sif_regs.sv
module codec_sif_regs
    import codec_sif_pkg::*;
#(
    parameter int DATA_W = REG_DW,
    parameter int ADDR_W = REG_AW,
    parameter int GAIN_W = 5,
    parameter int MUTE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_wr_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              short_l,
    input  logic              short_r,
    output logic [DATA_W-1:0] rd_data,
    output logic              chip_pd,
    output logic              loop_ana,
    output logic              loop_dig,
    output logic [DATA_W-1:0] pll_div,
    output logic [DATA_W-1:0] pll_mul,
    output logic [GAIN_W-1:0] rx_gain,
    output logic [MUTE_W-1:0] rx_mute_n,
    output logic [GAIN_W-1:0] tx_gain,
    output logic [MUTE_W-1:0] tx_mute_n
);

    localparam int VOL_W  = GAIN_W + MUTE_W;
    localparam int N_VOL  = 2;
    localparam logic [ADDR_W-1:0] VOL_ADDR [N_VOL] = '{A_RXVOL, A_TXVOL};
    localparam logic [VOL_W-1:0]  VOL_INIT = VOL_RESET[VOL_W-1:0];

    logic [2:0]       mode_q;
    logic [VOL_W-1:0] vol_q [N_VOL];
    logic [1:0]       stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            pll_div <= '0;
            pll_mul <= '0;
            stat_q  <= '0;
        end else begin
            stat_q <= {short_l, short_r};
            if (wr.we) begin
                if (wr.addr == A_MODE) mode_q  <= wr.data[3:1];
                if (wr.addr == A_DIV)  pll_div <= wr.data;
                if (wr.addr == A_MUL)  pll_mul <= wr.data;
            end
        end
    end

    for (genvar g = 0; g < N_VOL; g++) begin : g_vol
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                vol_q[g] <= VOL_INIT;
            else if (wr.we && wr.addr == VOL_ADDR[g])  vol_q[g] <= wr.data[VOL_W-1:0];
        end
    end

    assign chip_pd   = mode_q[2];
    assign loop_ana  = mode_q[1];
    assign loop_dig  = mode_q[0];
    assign rx_gain   = vol_q[0][VOL_W-1:MUTE_W];
    assign rx_mute_n = vol_q[0][MUTE_W-1:0];
    assign tx_gain   = vol_q[1][VOL_W-1:MUTE_W];
    assign tx_mute_n = vol_q[1][MUTE_W-1:0];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MODE:   rd_data = {4'b0000, mode_q, 1'b0};
            A_DIV:    rd_data = pll_div;
            A_MUL:    rd_data = pll_mul;
            A_RXVOL:  rd_data = DATA_W'(vol_q[0]);
            A_TXVOL:  rd_data = DATA_W'(vol_q[1]);
            A_STATUS: rd_data = {stat_q, {(DATA_W-2){1'b0}}};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/codec_sif.sv
module codec_sif
    import codec_sif_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [WORD_W-1:0] adc_sample,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    input  logic              short_l,
    input  logic              short_r,
    output logic              chip_pd,
    output logic              loop_ana,
    output logic              loop_dig,
    output logic [7:0]        pll_div,
    output logic [7:0]        pll_mul,
    output logic [4:0]        rx_gain,
    output logic [1:0]        rx_mute_n,
    output logic [4:0]        tx_gain,
    output logic [1:0]        tx_mute_n
);

    logic [2:0]        link_s;
    reg_wr_t           wr_bus;
    logic [REG_AW-1:0] rd_addr;
    logic [REG_DW-1:0] rd_data;
    sif_state_e        fr_state;
    logic              fr_rd_mode;
    logic              reg_we;

    assign reg_we = wr_bus.we;

    codec_sif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, fsync, sdi}),
        .q     (link_s)
    );

    codec_sif_frame #(.WORD_W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (link_s[2]),
        .fsync_s    (link_s[1]),
        .sdi_s      (link_s[0]),
        .adc_sample (adc_sample),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .dac_word   (dac_word),
        .dac_valid  (dac_valid),
        .wr         (wr_bus),
        .state      (fr_state),
        .rd_mode    (fr_rd_mode)
    );

    codec_sif_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_bus),
        .rd_addr   (rd_addr),
        .short_l   (short_l),
        .short_r   (short_r),
        .rd_data   (rd_data),
        .chip_pd   (chip_pd),
        .loop_ana  (loop_ana),
        .loop_dig  (loop_dig),
        .pll_div   (pll_div),
        .pll_mul   (pll_mul),
        .rx_gain   (rx_gain),
        .rx_mute_n (rx_mute_n),
        .tx_gain   (tx_gain),
        .tx_mute_n (tx_mute_n)
    );

endmodule

// File: rtl/codec_sif_chk.sv
module codec_sif_chk
    import codec_sif_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input sif_state_e state,
    input logic       rd_mode,
    input logic       dac_valid,
    input logic       sdo_oe,
    input logic       reg_we,
    input logic       chip_pd,
    input logic [4:0] rx_gain,
    input logic [1:0] rx_mute_n
);

    // R3
    dac_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R3
    dac_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(state) == ST_XFER_PRI);

    // R6
    write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(state) == ST_XFER_SEC);

    // R7
    sec_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && state == ST_XFER_SEC) |-> rd_mode);

    // R1
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (state == ST_XFER_PRI || state == ST_XFER_SEC));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable(chip_pd));

    // R9
    vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable({rx_gain, rx_mute_n}));

endmodule

bind codec_sif codec_sif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (fr_state),
    .rd_mode   (fr_rd_mode),
    .dac_valid (dac_valid),
    .sdo_oe    (sdo_oe),
    .reg_we    (reg_we),
    .chip_pd   (chip_pd),
    .rx_gain   (rx_gain),
    .rx_mute_n (rx_mute_n)
);

// File: tb/codec_sif_tb.sv
module codec_sif_tb;

    localparam int HALF = 8;
    localparam int NVEC = 6;
    // {host word (bit0 = 0), adc sample}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 16'hFFFF},
        {16'hA5A4, 16'h5A5A},
        {16'h8000, 16'h0001},
        {16'h7FFE, 16'h8000},
        {16'h1234, 16'hFEDC},
        {16'hFFFE, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, fsync = 1'b0, sdi = 1'b0;
    logic [15:0] adc_sample = '0;
    logic short_l = 1'b0, short_r = 1'b0;
    logic sdo, sdo_oe, dac_valid, chip_pd, loop_ana, loop_dig;
    logic [15:0] dac_word;
    logic [7:0] pll_div, pll_mul;
    logic [4:0] rx_gain, tx_gain;
    logic [1:0] rx_mute_n, tx_mute_n;

    int n_chk = 0, n_fail = 0, vcnt = 0;
    logic [15:0] vword = '0;
    logic [15:0] got, oem;
    logic [7:0] rd;
    int v0;

    always #10 clk = ~clk;

    codec_sif u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .adc_sample(adc_sample),
        .dac_word(dac_word), .dac_valid(dac_valid),
        .short_l(short_l), .short_r(short_r),
        .chip_pd(chip_pd), .loop_ana(loop_ana), .loop_dig(loop_dig),
        .pll_div(pll_div), .pll_mul(pll_mul),
        .rx_gain(rx_gain), .rx_mute_n(rx_mute_n),
        .tx_gain(tx_gain), .tx_mute_n(tx_mute_n)
    );

    always @(negedge clk) if (rst_n && dac_valid) begin
        vcnt  <= vcnt + 1;
        vword <= dac_word;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bit_time(input logic fs, input logic d,
                            output logic so, output logic soe);
        sclk = 1'b1; fsync = fs; sdi = d;
        repeat (HALF) @(negedge clk);
        so = sdo; soe = sdo_oe;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int idle,
                         input logic late, input logic [15:0] late_adc,
                         output logic [15:0] rx, output logic [15:0] en);
        logic so, soe;
        bit_time(1'b1, 1'b0, so, soe);
        if (late) adc_sample = late_adc;
        for (int i = 15; i >= 0; i--) begin
            bit_time(1'b0, w[i], so, soe);
            rx[i] = so; en[i] = soe;
        end
        for (int k = 0; k < idle; k++) bit_time(1'b0, 1'b0, so, soe);
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        logic [15:0] r, e;
        frame(16'h0001, 2, 1'b0, 16'h0, r, e);
        frame({3'b000, a, d}, 2, 1'b0, 16'h0, r, e);
        oem = e;
    endtask

    task automatic reg_read(input logic [4:0] a, input int gap, output logic [7:0] d);
        logic [15:0] r, e;
        frame(16'h0001, gap, 1'b0, 16'h0, r, e);
        frame({3'b001, a, 8'h00}, 2, 1'b0, 16'h0, r, e);
        d = r[7:0]; oem = e;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8 reset state at the ports
        check("R8", "sdo_oe", {31'h0, sdo_oe}, 32'h0);
        check("R8", "dac_valid", {31'h0, dac_valid}, 32'h0);
        check("R8", "rx vol", {25'h0, rx_gain, rx_mute_n}, 32'h5C);
        check("R8", "tx vol", {25'h0, tx_gain, tx_mute_n}, 32'h5C);
        check("R8", "pll", {16'h0, pll_div, pll_mul}, 32'h0);
        check("R8", "mode", {29'h0, chip_pd, loop_ana, loop_dig}, 32'h0);

        // R1 R3 table of primary frames
        for (int i = 0; i < NVEC; i++) begin
            adc_sample = VEC[i][15:0];
            v0 = vcnt;
            frame(VEC[i][31:16], 2, 1'b0, 16'h0, got, oem);
            check("R1", "sdo word", {16'h0, got}, {16'h0, VEC[i][15:0]});
            check("R1", "oe mask", {16'h0, oem}, 32'hFFFF);
            check("R3", "dac_word", {16'h0, vword}, {16'h0, VEC[i][31:16]});
            check("R3", "valid count", vcnt - v0, 1);
        end

        // R2 sample captured at frame start
        adc_sample = 16'hC3A5;
        frame(16'h0000, 2, 1'b1, 16'h1111, got, oem);
        check("R2", "late change ignored", {16'h0, got}, 32'hC3A5);

        // R8 R7 reset values read back, with one read at half-period spacing
        reg_read(5'h06, 111, rd); check("R8", "rxvol read", rd, 8'h5C);
        check("R7", "read oe mask", {16'h0, oem}, 32'h00FF);
        reg_read(5'h07, 2, rd); check("R8", "txvol read", rd, 8'h5C);
        reg_read(5'h01, 2, rd); check("R8", "mode read", rd, 8'h00);
        reg_read(5'h03, 2, rd); check("R8", "div read", rd, 8'h00);
        reg_read(5'h1F, 2, rd); check("R7", "unmapped read", rd, 8'h00);

        // R3 flag bit cleared on the parallel port
        frame(16'h3457, 2, 1'b0, 16'h0, got, oem);
        check("R3", "flag cleared", {16'h0, vword}, 32'h3456);
        frame(16'h0000, 2, 1'b0, 16'h0, got, oem);

        // R11 R6 divider/multiplier
        reg_write(5'h03, 8'h2A);
        check("R6", "write oe mask", {16'h0, oem}, 32'h0);
        reg_write(5'h04, 8'hC3);
        check("R11", "pll_div port", pll_div, 8'h2A);
        check("R11", "pll_mul port", pll_mul, 8'hC3);
        reg_read(5'h04, 2, rd); check("R11", "mul read", rd, 8'hC3);

        // R10 mode register
        reg_write(5'h01, 8'hFF);
        check("R10", "mode ports", {29'h0, chip_pd, loop_ana, loop_dig}, 32'h7);
        reg_read(5'h01, 2, rd); check("R10", "mode read", rd, 8'h0E);
        reg_write(5'h01, 8'h04);
        check("R10", "loop_ana only", {29'h0, chip_pd, loop_ana, loop_dig}, 32'h2);

        // R9 volume fields
        reg_write(5'h06, 8'hFF);
        check("R9", "rx ports", {25'h0, rx_gain, rx_mute_n}, 32'h7F);
        reg_read(5'h06, 2, rd); check("R9", "rx bit7 zero", rd, 8'h7F);
        reg_write(5'h07, 8'h01);
        check("R9", "tx ports", {25'h0, tx_gain, tx_mute_n}, 32'h01);

        // R12 status register
        short_l = 1'b1;
        repeat (4) @(negedge clk);
        reg_read(5'h0A, 2, rd); check("R12", "short_l", rd, 8'h80);
        reg_write(5'h0A, 8'h00);
        reg_read(5'h0A, 2, rd); check("R12", "write ignored", rd, 8'h80);
        short_l = 1'b0; short_r = 1'b1;
        reg_write(5'h0A, 8'hFF);
        reg_read(5'h0A, 2, rd); check("R12", "short_r only", rd, 8'h40);

        // R4 unflagged primary carrying a write-shaped word
        frame(16'h0000, 2, 1'b0, 16'h0, got, oem);
        v0 = vcnt;
        frame(16'h0398, 2, 1'b0, 16'h0, got, oem);
        check("R4", "treated as audio", {16'h0, vword}, 32'h0398);
        check("R4", "valid count", vcnt - v0, 1);
        check("R4", "pll_div untouched", pll_div, 8'h2A);

        // R5 secondary with bit0 = 1, next frame is primary
        reg_write(5'h03, 8'h2B);
        v0 = vcnt;
        frame(16'h0398, 2, 1'b0, 16'h0, got, oem);
        check("R5", "valid count", vcnt - v0, 1);
        check("R5", "pll_div kept", pll_div, 8'h2B);
        check("R5", "oe mask", {16'h0, oem}, 32'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule